// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the test access port of a chip's boundary-scan logic. It is clocked by the test clock and steered by the mode-select input. A sixteen-state controller walks through the standard capture, shift and update phases for two paths: the instruction path and the data path. A three-bit instruction, once applied, chooses which data register sits between the serial input and the serial output. The choices are the boundary chain, the one-bit bypass stage, an external probe chain and an external user register. The instruction also drives the control lines that take over the pads: output override, forced high impedance and clamp.

The block has no asynchronous test-reset pin. An active-low power-on reset puts the controller into Test-Logic-Reset. After that, five rising test-clock edges with mode-select high return it there from any state. The serial output changes on the falling test-clock edge. Its enable is high only while a shift state is active. When the enable is low, the pad is meant to float.

The probe chain and the user register sit outside the block. They take the serial input directly and are driven by the capture, shift and update strobes of the data path. Each returns one serial bit to the block.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `por_n` is low, the controller is in Test-Logic-Reset, `tdo_en` is 0, `pin_update` is all zeros and every select line is 0. Entering Test-Logic-Reset makes the active instruction BYPASS (111), so every select line reads 0.
- R2: Five consecutive rising `tck` edges with `tms` = 1 bring the controller to Test-Logic-Reset from any state. A later `tms` = 0 edge then moves it to Run-Test/Idle with BYPASS active.
- R3: Capture-IR loads 001 into the instruction shift stage. The instruction shifts least significant bit first, so the first three `tdo` bits of an instruction scan are 1, 0, 0. The shifted-in value becomes active at Update-IR.
- R4: `tdo_en` is 1 exactly while Shift-IR or Shift-DR is active. `tdo` and `tdo_en` change on the falling edge of `tck`.
- R5: Opcode 000 (EXTEST) raises `bscan_sel` and `pin_ovr`. Capture-DR loads `pin_capture` into the boundary chain. Shifting moves `tdi` into bit BSR_LEN-1 and sends bit 0 out on `tdo`. Update-DR copies the chain to `pin_update`, which changes at no other time.
- R6: Opcode 001 (SAMPLE/PRELOAD) raises `bscan_sel` with `pin_ovr` low. It captures, shifts and updates in the same way as R5.
- R7: Opcodes 111 and the unused 010 raise no select line. The data path is the one-bit bypass stage, which captures 0, so the data scan returns 0 followed by `tdi` delayed by one bit. `pin_update` is unchanged.
- R8: Opcode 011 raises `probe_sel`, and 100 raises `user_sel`. In Shift-DR, `tdo` carries `probe_tdo` or `user_tdo` respectively.
- R9: Opcode 101 (HIGHZ) raises `force_hiz` alone and selects the bypass stage. `pin_update` is unchanged.
- R10: Opcode 110 (CLAMP) raises `clamp_mode` and `pin_ovr` and selects the bypass stage. `pin_update` keeps the values preloaded earlier.
- R11: `dr_capture`, `dr_shift` and `dr_update` are each 1 exactly in Capture-DR, Shift-DR and Update-DR respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Active-low power-on reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pin_capture | input | BSR_LEN | Pad values seen by the boundary chain |
| probe_tdo | input | 1 | Serial return of the external probe chain |
| user_tdo | input | 1 | Serial return of the external user register |
| tdo | output | 1 | Serial data out, changed on the falling edge |
| tdo_en | output | 1 | Output enable for the tdo pad |
| pin_update | output | BSR_LEN | Boundary update latches driven to the pads |
| bscan_sel | output | 1 | Boundary chain is the selected data register |
| pin_ovr | output | 1 | Pad outputs taken over by the update latches |
| force_hiz | output | 1 | Force all pad outputs to high impedance |
| clamp_mode | output | 1 | Clamp mode active |
| probe_sel | output | 1 | Probe chain selected |
| user_sel | output | 1 | User register selected |
| dr_capture | output | 1 | Data path in Capture-DR |
| dr_shift | output | 1 | Data path in Shift-DR |
| dr_update | output | 1 | Data path in Update-DR |

## Verification
The bench builds the block with BSR_LEN = 6 and uses data scans 10 bits long. Every boundary scan therefore pushes the whole captured word out and then four more bits of `tdi`. This shows both the capture contents and the chain's serial delay, and it leaves a known word in the latches before Update-DR. The short chain allows dozens of random instruction-and-scan rounds, including all eight opcodes and random walks of the controller that end in a five-edge reset, inside a small cycle budget.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int unsigned IR_LEN = 3;
    typedef logic [IR_LEN-1:0] opcode_t;

    localparam opcode_t OP_EXTEST = 3'b000;
    localparam opcode_t OP_SAMPLE = 3'b001;
    localparam opcode_t OP_PROBE  = 3'b011;
    localparam opcode_t OP_USER   = 3'b100;
    localparam opcode_t OP_HIGHZ  = 3'b101;
    localparam opcode_t OP_CLAMP  = 3'b110;
    localparam opcode_t OP_BYPASS = 3'b111;
    localparam opcode_t IR_CAPTURE_PAT = 3'b001;

    typedef struct packed {
        logic bscan_sel;
        logic pin_ovr;
        logic hiz;
        logic clamp;
        logic probe_sel;
        logic user_sel;
        logic upd_ok;
    } ir_dec_t;

    function automatic ir_dec_t decode_op(opcode_t op);
        ir_dec_t d;
        d = '0;
        case (op)
            OP_EXTEST: begin
                d.bscan_sel = 1'b1;
                d.pin_ovr   = 1'b1;
                d.upd_ok    = 1'b1;
            end
            OP_SAMPLE: begin
                d.bscan_sel = 1'b1;
                d.upd_ok    = 1'b1;
            end
            OP_PROBE:  d.probe_sel = 1'b1;
            OP_USER:   d.user_sel  = 1'b1;
            OP_HIGHZ:  d.hiz       = 1'b1;
            OP_CLAMP: begin
                d.clamp   = 1'b1;
                d.pin_ovr = 1'b1;
                d.upd_ok  = 1'b1;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        tap_state_e n;
        case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.st = tap_next(r_q.st, tms);
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            r_q.st <= ST_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tdi,
    input  tap_state_e state,
    output logic       ir_bit,
    output ir_dec_t    dec
);

    typedef struct packed {
        opcode_t sh;
        opcode_t act;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            ST_RESET:  r_d.act = OP_BYPASS;
            ST_CAP_IR: r_d.sh  = IR_CAPTURE_PAT;
            ST_SH_IR:  r_d.sh  = {tdi, r_q.sh[IR_LEN-1:1]};
            ST_UPD_IR: r_d.act = r_q.sh;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            r_q.sh  <= IR_CAPTURE_PAT;
            r_q.act <= OP_BYPASS;
        end else begin
            r_q <= r_d;
        end
    end

    assign ir_bit = r_q.sh[0];
    assign dec    = decode_op(r_q.act);

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int unsigned BSR_LEN = 16
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tdi,
    input  tap_state_e         state,
    input  logic               bsr_sel,
    input  logic               upd_ok,
    input  logic [BSR_LEN-1:0] pin_capture,
    output logic               bsr_bit,
    output logic               byp_bit,
    output logic [BSR_LEN-1:0] pin_update
);

    typedef struct packed {
        logic [BSR_LEN-1:0] sh;
        logic [BSR_LEN-1:0] upd;
        logic               byp;
    } dr_regs_t;

    dr_regs_t r_d, r_q;
    logic [BSR_LEN-1:0] sh_shifted;

    // New bit enters at the top; bit 0 is the serial output.
    generate
        if (BSR_LEN == 1) begin : g_single
            assign sh_shifted = tdi;
        end else begin : g_chain
            assign sh_shifted = {tdi, r_q.sh[BSR_LEN-1:1]};
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        case (state)
            ST_CAP_DR: begin
                r_d.byp = 1'b0;
                if (bsr_sel) r_d.sh = pin_capture;
            end
            ST_SH_DR: begin
                r_d.byp = tdi;
                if (bsr_sel) r_d.sh = sh_shifted;
            end
            ST_UPD_DR: begin
                if (upd_ok) r_d.upd = r_q.sh;
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bsr_bit    = r_q.sh[0];
    assign byp_bit    = r_q.byp;
    assign pin_update = r_q.upd;

endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter int unsigned BSR_LEN = 16
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_capture,
    input  logic               probe_tdo,
    input  logic               user_tdo,
    output logic               tdo,
    output logic               tdo_en,
    output logic [BSR_LEN-1:0] pin_update,
    output logic               bscan_sel,
    output logic               pin_ovr,
    output logic               force_hiz,
    output logic               clamp_mode,
    output logic               probe_sel,
    output logic               user_sel,
    output logic               dr_capture,
    output logic               dr_shift,
    output logic               dr_update
);

    tap_state_e tap_state;
    ir_dec_t    dec;
    logic       ir_bit, bsr_bit, byp_bit;

    scan_tap_fsm u_fsm (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms),
        .state (tap_state)
    );

    scan_tap_ir u_ir (
        .tck    (tck),
        .por_n  (por_n),
        .tdi    (tdi),
        .state  (tap_state),
        .ir_bit (ir_bit),
        .dec    (dec)
    );

    scan_tap_dr #(.BSR_LEN(BSR_LEN)) u_dr (
        .tck         (tck),
        .por_n       (por_n),
        .tdi         (tdi),
        .state       (tap_state),
        .bsr_sel     (dec.bscan_sel),
        .upd_ok      (dec.upd_ok),
        .pin_capture (pin_capture),
        .bsr_bit     (bsr_bit),
        .byp_bit     (byp_bit),
        .pin_update  (pin_update)
    );

    // Serial output stage, retimed to the falling edge.
    typedef struct packed {
        logic tdo;
        logic en;
    } out_regs_t;

    out_regs_t o_d, o_q;
    logic      dr_src;

    always_comb begin
        if (dec.bscan_sel)      dr_src = bsr_bit;
        else if (dec.probe_sel) dr_src = probe_tdo;
        else if (dec.user_sel)  dr_src = user_tdo;
        else                    dr_src = byp_bit;

        o_d     = o_q;
        o_d.en  = (tap_state == ST_SH_IR) || (tap_state == ST_SH_DR);
        o_d.tdo = 1'b0;
        if (tap_state == ST_SH_IR)      o_d.tdo = ir_bit;
        else if (tap_state == ST_SH_DR) o_d.tdo = dr_src;
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign tdo        = o_q.tdo;
    assign tdo_en     = o_q.en;
    assign bscan_sel  = dec.bscan_sel;
    assign pin_ovr    = dec.pin_ovr;
    assign force_hiz  = dec.hiz;
    assign clamp_mode = dec.clamp;
    assign probe_sel  = dec.probe_sel;
    assign user_sel   = dec.user_sel;
    assign dr_capture = (tap_state == ST_CAP_DR);
    assign dr_shift   = (tap_state == ST_SH_DR);
    assign dr_update  = (tap_state == ST_UPD_DR);

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
    import scan_tap_pkg::*;
#(
    parameter int unsigned BSR_LEN = 16
) (
    input logic               tck,
    input logic               por_n,
    input logic               tms,
    input tap_state_e         tap_state,
    input logic               tdo_en,
    input logic [BSR_LEN-1:0] pin_update,
    input logic               bscan_sel,
    input logic               pin_ovr,
    input logic               force_hiz,
    input logic               clamp_mode,
    input logic               probe_sel,
    input logic               user_sel
);

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)          ones_q <= '0;
        else if (!tms)       ones_q <= '0;
        else if (ones_q < 5) ones_q <= ones_q + 3'd1;
    end

    p_tms_reset_r2: assert property (@(posedge tck) disable iff (!por_n)
        (ones_q == 3'd5) |-> (tap_state == ST_RESET));

    p_tdo_en_shift_r4: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en == ((tap_state == ST_SH_IR) || (tap_state == ST_SH_DR)));

    p_reset_bypass_r1: assert property (@(posedge tck) disable iff (!por_n)
        (tap_state == ST_RESET) |=>
        !(bscan_sel || pin_ovr || force_hiz || clamp_mode || probe_sel || user_sel));

    p_one_mode_r8: assert property (@(posedge tck) disable iff (!por_n)
        $onehot0({bscan_sel, force_hiz, clamp_mode, probe_sel, user_sel}));

    p_update_hold_r5: assert property (@(posedge tck) disable iff (!por_n)
        (tap_state != ST_UPD_DR) |=> $stable(pin_update));

    p_clamp_ovr_r10: assert property (@(posedge tck) disable iff (!por_n)
        clamp_mode |-> (pin_ovr && !bscan_sel));

endmodule

bind scan_tap_ctrl scan_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck        (tck),
    .por_n      (por_n),
    .tms        (tms),
    .tap_state  (tap_state),
    .tdo_en     (tdo_en),
    .pin_update (pin_update),
    .bscan_sel  (bscan_sel),
    .pin_ovr    (pin_ovr),
    .force_hiz  (force_hiz),
    .clamp_mode (clamp_mode),
    .probe_sel  (probe_sel),
    .user_sel   (user_sel)
);

// File: tb/scan_tap_ctrl_tb.sv
`timescale 1ns/1ps
module scan_tap_ctrl_tb;

    localparam int N    = 6;
    localparam int DR_L = N + 4;

    logic         tck = 1'b0;
    logic         por_n, tms, tdi, probe_tdo, user_tdo;
    logic [N-1:0] pin_capture;
    logic         tdo, tdo_en;
    logic [N-1:0] pin_update;
    logic bscan_sel, pin_ovr, force_hiz, clamp_mode, probe_sel, user_sel;
    logic dr_capture, dr_shift, dr_update;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 tck = ~tck;

    scan_tap_ctrl #(.BSR_LEN(N)) u_dut (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi),
        .pin_capture(pin_capture), .probe_tdo(probe_tdo), .user_tdo(user_tdo),
        .tdo(tdo), .tdo_en(tdo_en), .pin_update(pin_update),
        .bscan_sel(bscan_sel), .pin_ovr(pin_ovr), .force_hiz(force_hiz),
        .clamp_mode(clamp_mode), .probe_sel(probe_sel), .user_sel(user_sel),
        .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {bscan_sel, pin_ovr, force_hiz, clamp_mode, probe_sel, user_sel}
    function automatic logic [5:0] exp_sel(input logic [2:0] op);
        case (op)
            3'b000:  return 6'b110000;
            3'b001:  return 6'b100000;
            3'b011:  return 6'b000010;
            3'b100:  return 6'b000001;
            3'b101:  return 6'b001000;
            3'b110:  return 6'b010100;
            default: return 6'b000000;
        endcase
    endfunction

    function automatic logic [DR_L-1:0] exp_dr_out(input logic [2:0] op, input logic [N-1:0] cap,
                                                   input logic [DR_L-1:0] din, input logic p, input logic u);
        logic [DR_L-1:0] r;
        for (int i = 0; i < DR_L; i++) begin
            if (op == 3'b000 || op == 3'b001) r[i] = (i < N) ? cap[i] : din[i-N];
            else if (op == 3'b011)            r[i] = p;
            else if (op == 3'b100)            r[i] = u;
            else                              r[i] = (i == 0) ? 1'b0 : din[i-1];
        end
        return r;
    endfunction

    function automatic logic [N-1:0] exp_upd(input logic [2:0] op, input logic [N-1:0] prev,
                                             input logic [DR_L-1:0] din);
        if (op == 3'b000 || op == 3'b001) return din[DR_L-1 -: N];
        return prev;
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'b000:          return "R5";
            3'b001:          return "R6";
            3'b011, 3'b100:  return "R8";
            3'b101:          return "R9";
            3'b110:          return "R10";
            default:         return "R7";
        endcase
    endfunction

    // Sample outputs just after the falling edge, then drive for the next rising edge.
    task automatic tick(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        #2;
        o = tdo;
        e = tdo_en;
        tms = m;
        tdi = d;
    endtask

    task automatic settle();
        @(negedge tck);
        #2;
    endtask

    task automatic ir_load(input logic [2:0] op);
        logic o, e;
        logic [2:0] got;
        tick(1, 0, o, e);
        tick(1, 0, o, e);
        tick(0, 0, o, e);
        tick(0, 0, o, e);
        check(e == 1'b0, "R4 tdo_en low in Capture-IR", e, 0);
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, op[i], o, e);
            got[i] = o;
            if (i > 0) check(e == 1'b1, "R4 tdo_en high in Shift-IR", e, 1);
        end
        check(got == 3'b001, "R3 captured instruction pattern", got, 3'b001);
        tick(1, 0, o, e);
        tick(0, 0, o, e);
        settle();
        check({bscan_sel, pin_ovr, force_hiz, clamp_mode, probe_sel, user_sel} == exp_sel(op),
              {req_of(op), " select lines"},
              {bscan_sel, pin_ovr, force_hiz, clamp_mode, probe_sel, user_sel}, exp_sel(op));
    endtask

    task automatic dr_scan(input logic [2:0] op, input logic [DR_L-1:0] din);
        logic o, e;
        logic [DR_L-1:0] got, want;
        logic [N-1:0] prev;
        prev = pin_update;
        want = exp_dr_out(op, pin_capture, din, probe_tdo, user_tdo);
        tick(1, 0, o, e);
        tick(0, 0, o, e);
        tick(0, 0, o, e);
        check(dr_capture == 1'b1 && dr_shift == 1'b0, "R11 dr_capture in Capture-DR",
              {dr_capture, dr_shift}, 2'b10);
        for (int i = 0; i < DR_L; i++) begin
            tick(i == DR_L - 1, din[i], o, e);
            got[i] = o;
            if (i == 0) check(dr_shift == 1'b1, "R11 dr_shift in Shift-DR", dr_shift, 1);
        end
        check(got == want, {req_of(op), " data scan output"}, got, want);
        tick(1, 0, o, e);
        check(e == 1'b0, "R4 tdo_en low in Exit1-DR", e, 0);
        tick(0, 0, o, e);
        check(dr_update == 1'b1, "R11 dr_update in Update-DR", dr_update, 1);
        settle();
        check(pin_update == exp_upd(op, prev, din), {req_of(op), " update latches"},
              pin_update, exp_upd(op, prev, din));
    endtask

    task automatic tms_reset(input int walk);
        logic o, e;
        for (int i = 0; i < walk; i++) tick(1'($urandom % 2), 1'($urandom % 2), o, e);
        for (int i = 0; i < 5; i++) tick(1, 0, o, e);
        tick(0, 0, o, e);
        settle();
        check({bscan_sel, pin_ovr, force_hiz, clamp_mode, probe_sel, user_sel} == 6'b0 && tdo_en == 1'b0,
              "R2 five-high reset to BYPASS",
              {tdo_en, bscan_sel, pin_ovr, force_hiz, clamp_mode, probe_sel, user_sel}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic o, e;
        void'($urandom(32'h0051_7EAD));
        por_n = 1'b0; tms = 1'b1; tdi = 1'b0;
        pin_capture = '0; probe_tdo = 1'b0; user_tdo = 1'b0;
        repeat (3) settle();
        check(tdo_en == 1'b0 && pin_update == '0, "R1 reset outputs", {tdo_en, pin_update}, 0);
        check({bscan_sel, pin_ovr, force_hiz, clamp_mode, probe_sel, user_sel} == 6'b0,
              "R1 reset selects BYPASS",
              {bscan_sel, pin_ovr, force_hiz, clamp_mode, probe_sel, user_sel}, 0);
        por_n = 1'b1;
        tick(1, 0, o, e);
        tick(0, 0, o, e);

        // Directed corner cases
        pin_capture = 6'b101101;
        ir_load(3'b000); dr_scan(3'b000, 10'b11_0100_1011);
        ir_load(3'b001); dr_scan(3'b001, 10'b01_1110_0010);
        ir_load(3'b110); dr_scan(3'b110, 10'b10_1010_1010);
        ir_load(3'b010); dr_scan(3'b010, 10'b00_1111_0001);
        probe_tdo = 1'b1;
        ir_load(3'b011); dr_scan(3'b011, 10'b01_0101_0101);
        user_tdo = 1'b1; probe_tdo = 1'b0;
        ir_load(3'b100); dr_scan(3'b100, 10'b11_0011_0011);
        ir_load(3'b101); dr_scan(3'b101, 10'b10_0000_0001);
        ir_load(3'b000);
        tick(1, 0, o, e); tick(0, 0, o, e); tick(0, 0, o, e); tick(0, 1, o, e);
        tms_reset(0);

        // Random rounds
        for (int k = 0; k < 40; k++) begin
            logic [2:0] op;
            logic [DR_L-1:0] din;
            op          = 3'($urandom);
            din         = DR_L'($urandom);
            pin_capture = N'($urandom);
            probe_tdo   = 1'($urandom);
            user_tdo    = 1'($urandom);
            ir_load(op);
            dr_scan(op, din);
            if (k % 4 == 3) tms_reset(int'($urandom % 9));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule